// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block is a single-channel data mover that takes its work from a circular ring of 128-bit descriptors in memory. Software writes descriptors into the ring, then writes a new head index. The engine walks from its tail index up to, but not including, the head. It fetches both 64-bit words of each descriptor, executes the descriptor, and only then moves the tail on by one slot. Indices wrap at the ring depth.

There are two descriptor kinds. A copy descriptor moves a block of memory from a source address to a destination address, one 64-bit word at a time. Its size is given in 64-byte units. A status descriptor stores a 64-bit value at an address, and it can flag an interrupt once that store has been accepted. Descriptors run strictly one at a time in ring order, so a status store always lands after every write of the copies before it.

Two faults stop the channel: a descriptor of unknown kind, and a head write that repeats the current head value. Software would otherwise read such a repeated write as a full ring refill that overwrote live entries. A stopped channel masks its interrupt output and ignores further head writes until reset.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset the head, tail, ring base, error and status registers read zero, `irq` is low and `mem_req` is low.
- R2: A head write makes the engine execute the slots from the tail up to, but not including, the new head, in order. The tail advances by exactly one per finished descriptor and wraps from RING_DEPTH-1 to 0.
- R3: The first word of the descriptor at index i is read from ring base + 16*i and the second word from ring base + 16*i + 8. A memory request holds its address and direction until `mem_ready` accepts it.
- R4: A descriptor whose second word has bits 63:60 equal to 1 is a copy. The source address is in the low ADDR_W bits of word 0, the destination address is in the low ADDR_W bits of word 1, and the length in 64-byte units is in word 0 starting at bit 46 (LEN_W bits). The engine writes 8 words per unit to ascending destination addresses, each word being the value read from the matching source address. A length of zero writes nothing.
- R5: A descriptor whose type field is 2 is a status store. Word 0 is written to the address in the low ADDR_W bits of word 1, after all writes of earlier descriptors.
- R6: If bit 59 of a status descriptor's second word is set, `irq` goes high after that store and stays high until software writes 1 in bit 0 of the acknowledge register (offset 5). Writing 0 there has no effect.
- R7: A status store with bit 59 clear leaves `irq` low.
- R8: A head write equal to the current head sets error bit 1 (offset 3) and halts the channel (status bit 0 at offset 4). No new descriptor is fetched after that.
- R9: A type field other than 1 or 2 sets error bit 0 and halts the channel. The tail is not advanced, and the descriptor causes no memory write.
- R10: While halted, `irq` is held low even if an interrupt is pending, and head writes are ignored.
- R11: Register offsets on `reg_addr`: 0 head (read/write), 1 tail (read), 2 ring base (read/write), 3 error, 4 status (bit 0 halted, bit 1 busy, bit 2 interrupt pending), 5 acknowledge (write). Read data is combinational and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data at `reg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Memory accepts the request in this cycle |
| mem_rvalid | input | 1 | Read data valid (one response per accepted read) |
| mem_rdata | input | 64 | Read data |
| irq | output | 1 | Interrupt level |

## Verification
A wrong tail index or a wrong ring base shows at the ports on the very next fetch. The descriptor read goes to the wrong slot, and the following write then carries a wrong address or data, which the scoreboard catches in the same cycle the write is accepted. A bad remaining-word count shows up as a missing or extra copy write before the tail moves. Faulty error or interrupt state becomes visible on `irq`, or in the error and status registers, within a few cycles of the status store or the fault. A lost halt shows as fresh memory requests after the fault.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int DW        = 64;
  localparam int KIND_LSB  = 60;
  localparam int FLAG_BIT  = 59;
  localparam int SIZE_LSB  = 46;

  localparam logic [3:0] KIND_COPY   = 4'd1;
  localparam logic [3:0] KIND_STATUS = 4'd2;

  localparam logic [2:0] OFS_HEAD = 3'd0;
  localparam logic [2:0] OFS_TAIL = 3'd1;
  localparam logic [2:0] OFS_BASE = 3'd2;
  localparam logic [2:0] OFS_ERR  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam logic [2:0] OFS_ACK  = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F0W, ST_F1, ST_F1W, ST_EXEC,
    ST_CRD, ST_CRW, ST_CWR, ST_SWR, ST_ADV, ST_HALT
  } eng_state_e;
endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic              busy_i,
  input  logic              bad_kind_ev,
  input  logic              irq_set_ev,
  output logic [IDX_W-1:0]  head_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              halted_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  head_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        err_q;
  logic              pend_q;

  // named events for the checks below
  logic head_wr_ev, dup_head_ev, base_wr_ev, ack_ev;
  assign head_wr_ev  = reg_wr && (reg_addr == OFS_HEAD) && !halted_o;
  assign dup_head_ev = head_wr_ev && (reg_wdata[IDX_W-1:0] == head_q);
  assign base_wr_ev  = reg_wr && (reg_addr == OFS_BASE);
  assign ack_ev      = reg_wr && (reg_addr == OFS_ACK) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      base_q <= '0;
      err_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (head_wr_ev)  head_q   <= reg_wdata[IDX_W-1:0];
      if (base_wr_ev)  base_q   <= reg_wdata;
      if (bad_kind_ev) err_q[0] <= 1'b1;
      if (dup_head_ev) err_q[1] <= 1'b1;
      if (irq_set_ev)  pend_q   <= 1'b1;
      else if (ack_ev) pend_q   <= 1'b0;
    end
  end

  assign head_o   = head_q;
  assign base_o   = base_q;
  assign halted_o = |err_q;
  assign irq_o    = pend_q && !halted_o;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_HEAD: reg_rdata = ADDR_W'(head_q);
      OFS_TAIL: reg_rdata = ADDR_W'(tail_i);
      OFS_BASE: reg_rdata = base_q;
      OFS_ERR:  reg_rdata = ADDR_W'(err_q);
      OFS_STAT: reg_rdata = ADDR_W'({pend_q, busy_i, halted_o});
      default:  reg_rdata = '0;
    endcase
  end

  // R8
  dup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_head_ev |=> (err_q[1] && halted_o));
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_ev) |=> pend_q);
  // R10
  head_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> $stable(head_q));
endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  head_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              halted_i,
  output logic [IDX_W-1:0]  tail_o,
  output logic              busy_o,
  output logic              bad_kind_ev,
  output logic              irq_set_ev,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int CNT_W = LEN_W + 3;

  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] i);
    return (32'(i) == DEPTH - 1) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic upper);
    return base + (ADDR_W'(i) << 4) + ADDR_W'(upper ? 8 : 0);
  endfunction

  function automatic logic [CNT_W-1:0] unit_words(input logic [LEN_W-1:0] units);
    return CNT_W'(units) << 3;
  endfunction

  eng_state_e        state;
  logic [IDX_W-1:0]  tail_q;
  logic [DW-1:0]     w0_q, buf_q;
  logic [3:0]        kind_q;
  logic              flag_q;
  logic [ADDR_W-1:0] dst_q, rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  remain;

  logic tail_adv_ev;
  assign tail_adv_ev = (state == ST_ADV);
  assign bad_kind_ev = (state == ST_EXEC) && (kind_q != KIND_COPY) && (kind_q != KIND_STATUS);
  assign irq_set_ev  = tail_adv_ev && (kind_q == KIND_STATUS) && flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tail_q <= '0;
      w0_q   <= '0;
      buf_q  <= '0;
      kind_q <= '0;
      flag_q <= 1'b0;
      dst_q  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: if (halted_i) state <= ST_HALT;
                 else if (tail_q != head_i) state <= ST_F0;
        ST_F0:   if (mem_ready) state <= ST_F0W;
        ST_F0W:  if (mem_rvalid) begin
                   w0_q  <= mem_rdata;
                   state <= ST_F1;
                 end
        ST_F1:   if (mem_ready) state <= ST_F1W;
        ST_F1W:  if (mem_rvalid) begin
                   kind_q <= mem_rdata[KIND_LSB+:4];
                   flag_q <= mem_rdata[FLAG_BIT];
                   dst_q  <= mem_rdata[ADDR_W-1:0];
                   state  <= ST_EXEC;
                 end
        ST_EXEC: begin
          if (kind_q == KIND_COPY) begin
            rd_ptr <= w0_q[ADDR_W-1:0];
            wr_ptr <= dst_q;
            remain <= unit_words(w0_q[SIZE_LSB+:LEN_W]);
            state  <= (w0_q[SIZE_LSB+:LEN_W] == '0) ? ST_ADV : ST_CRD;
          end else if (kind_q == KIND_STATUS) begin
            state <= ST_SWR;
          end else begin
            state <= ST_HALT;
          end
        end
        ST_CRD:  if (mem_ready) state <= ST_CRW;
        ST_CRW:  if (mem_rvalid) begin
                   buf_q <= mem_rdata;
                   state <= ST_CWR;
                 end
        ST_CWR:  if (mem_ready) begin
                   rd_ptr <= rd_ptr + ADDR_W'(8);
                   wr_ptr <= wr_ptr + ADDR_W'(8);
                   remain <= remain - 1'b1;
                   state  <= (remain == CNT_W'(1)) ? ST_ADV : ST_CRD;
                 end
        ST_SWR:  if (mem_ready) state <= ST_ADV;
        ST_ADV: begin
          tail_q <= ring_next(tail_q);
          state  <= ST_IDLE;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_F0:  begin mem_req = 1'b1; mem_addr = slot_addr(base_i, tail_q, 1'b0); end
      ST_F1:  begin mem_req = 1'b1; mem_addr = slot_addr(base_i, tail_q, 1'b1); end
      ST_CRD: begin mem_req = 1'b1; mem_addr = rd_ptr; end
      ST_CWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_ptr; mem_wdata = buf_q; end
      ST_SWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst_q; mem_wdata = w0_q; end
      default: ;
    endcase
  end

  assign tail_o = tail_q;
  assign busy_o = (state != ST_IDLE) && (state != ST_HALT);

  // R2
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q != $past(tail_q)) |-> (tail_q == ring_next($past(tail_q))));
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R9
  bad_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kind_ev |=> (state == ST_HALT && $stable(tail_q) && !mem_req));
  // R5
  status_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SWR) |-> (remain == '0));
  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> !mem_req);
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RING_DEPTH = 16,
  parameter int LEN_W      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              irq
);
  localparam int IDX_W = $clog2(RING_DEPTH);

  logic [IDX_W-1:0]  head_w, tail_w;
  logic [ADDR_W-1:0] base_w;
  logic halted_w, busy_w, bad_kind_w, irq_set_w;

  ring_dma_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tail_i(tail_w), .busy_i(busy_w), .bad_kind_ev(bad_kind_w), .irq_set_ev(irq_set_w),
    .head_o(head_w), .base_o(base_w), .halted_o(halted_w), .irq_o(irq)
  );

  ring_dma_seq #(.ADDR_W(ADDR_W), .DEPTH(RING_DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .head_i(head_w), .base_i(base_w), .halted_i(halted_w),
    .tail_o(tail_w), .busy_o(busy_w), .bad_kind_ev(bad_kind_w), .irq_set_ev(irq_set_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/test_ring_dma_engine.sv
module test_ring_dma_engine;
  localparam logic [2:0] A_HEAD = 3'd0, A_TAIL = 3'd1, A_BASE = 3'd2,
                         A_ERR = 3'd3, A_STAT = 3'd4, A_ACK = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, irq;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic mem_ready = 1'b1, mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #10 clk = ~clk;

  ring_dma_engine i_ring_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .irq(irq)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit stall_on = 0, done = 0;
  logic [31:0] rb = 32'h1000;
  logic [63:0] mem [logic [31:0]];
  logic [31:0] exp_a[$];
  logic [63:0] exp_d[$];
  string exp_t[$];
  bit rd_pend = 0;
  logic [31:0] rd_at;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and write monitor (scoreboard pop side)
  always @(negedge clk) begin
    cyc++;
    mem_ready = !stall_on || (cyc % 3 != 0);
    mem_rvalid = 1'b0;
    if (rd_pend) begin
      mem_rvalid = 1'b1;
      mem_rdata = mem.exists(rd_at) ? mem[rd_at] : 64'h0;
      rd_pend = 0;
    end
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        if (exp_a.size() == 0) chk("R9 no unexpected write", {32'h0, mem_addr}, 64'hFFFF_FFFF);
        else begin
          string t = exp_t.pop_front();
          chk({t, " addr"}, {32'h0, mem_addr}, {32'h0, exp_a.pop_front()});
          chk({t, " data"}, mem_wdata, exp_d.pop_front());
        end
      end else begin
        rd_pend = 1;
        rd_at = mem_addr;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_reg(input logic [2:0] a, input logic [31:0] target);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(a, v);
      if (v == target) break;
    end
  endtask

  task automatic push(input string t, input logic [31:0] a, input logic [63:0] d);
    exp_t.push_back(t); exp_a.push_back(a); exp_d.push_back(d);
  endtask

  task automatic fill_src(input logic [31:0] src, input int n, input logic [15:0] seed);
    for (int i = 0; i < n; i++) mem[src + 32'(8 * i)] = {seed, 16'h5A5A, 32'(i * 7 + 3)};
  endtask

  task automatic put_raw(input int idx, input logic [63:0] w0, input logic [63:0] w1);
    mem[rb + 32'(16 * idx)] = w0;
    mem[rb + 32'(16 * idx) + 8] = w1;
  endtask

  task automatic put_copy(input int idx, input logic [31:0] src, input logic [31:0] dst,
                          input int units, input string t);
    put_raw(idx, (64'(units) << 46) | 64'(src), {4'd1, 60'(dst)});
    for (int i = 0; i < units * 8; i++)
      push(t, dst + 32'(8 * i), mem[src + 32'(8 * i)]);
  endtask

  task automatic put_status(input int idx, input logic [63:0] d, input logic [31:0] a,
                            input bit fl, input string t);
    put_raw(idx, d, {4'd2, fl, 59'(a)});
    push(t, a, d);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    chk("R1 mem_req", 64'(mem_req), 0);
    rst_n = 1'b1;
    rd(A_HEAD, v); chk("R1 head", 64'(v), 0);
    rd(A_TAIL, v); chk("R1 tail", 64'(v), 0);
    rd(A_ERR, v);  chk("R1 err", 64'(v), 0);
    rd(A_STAT, v); chk("R1 stat", 64'(v), 0);
    rd(A_BASE, v); chk("R1 base", 64'(v), 0);

    // R11 base register, R4 copy then R5 status without flag (R7)
    wr(A_BASE, rb);
    rd(A_BASE, v); chk("R11 base readback", 64'(v), 64'(rb));
    fill_src(32'h4000, 8, 16'h0001);
    put_copy(0, 32'h4000, 32'h8000, 1, "R4 copy");
    put_status(1, 64'h1122_3344_5566_7788, 32'h9000, 0, "R5 status");
    wr(A_HEAD, 2);
    wait_reg(A_TAIL, 2);
    rd(A_TAIL, v); chk("R2 tail after two", 64'(v), 2);
    chk("R4 all copy writes seen", 64'(exp_a.size()), 0);
    chk("R7 no irq", 64'(irq), 0);
    rd(A_STAT, v); chk("R11 stat idle", 64'(v), 0);

    // R6 interrupting status store
    put_status(2, 64'hDEAD_BEEF_0000_0001, 32'h9008, 1, "R6 status");
    wr(A_HEAD, 3);
    wait_reg(A_TAIL, 3);
    repeat (2) @(negedge clk);
    chk("R6 irq set", 64'(irq), 1);
    repeat (20) @(negedge clk);
    chk("R6 irq held", 64'(irq), 1);
    rd(A_STAT, v); chk("R11 stat pending bit", 64'(v), 4);
    wr(A_ACK, 0);
    chk("R6 ack of zero ignored", 64'(irq), 1);
    wr(A_ACK, 1);
    chk("R6 irq cleared", 64'(irq), 0);

    // R4 zero-length copy writes nothing
    put_copy(3, 32'h4000, 32'hF000, 0, "R4 zero");
    put_status(4, 64'h0000_0000_0000_00AA, 32'h9010, 0, "R4 after zero");
    wr(A_HEAD, 5);
    wait_reg(A_TAIL, 5);
    chk("R4 zero length only status", 64'(exp_a.size()), 0);

    // R2 wrap, R3 fetch addresses, R5 ordering, with stalls
    stall_on = 1;
    fill_src(32'h5000, 16, 16'h0002);
    fill_src(32'h6000, 8, 16'h0003);
    put_copy(5, 32'h5000, 32'hA000, 2, "R3 wrap copy");
    for (int k = 6; k < 16; k++)
      put_status(k, 64'(k) * 64'h0101, 32'hB000 + 32'(8 * k), 0, "R5 wrap status");
    put_status(0, 64'h0F0F, 32'hB100, 0, "R5 wrap status0");
    put_copy(1, 32'h6000, 32'hC000, 1, "R3 wrap copy1");
    wr(A_HEAD, 2);
    wait_reg(A_TAIL, 2);
    rd(A_TAIL, v); chk("R2 tail wrapped", 64'(v), 2);
    chk("R5 ordered writes consumed", 64'(exp_a.size()), 0);
    stall_on = 0;

    // R9 unknown type, R10 masking
    put_status(2, 64'h7777, 32'hD000, 1, "R9 status before bad");
    put_raw(3, 64'h0, {4'd3, 60'h0});
    wr(A_HEAD, 4);
    wait_reg(A_ERR, 1);
    repeat (5) @(negedge clk);
    rd(A_ERR, v);  chk("R9 err bit0", 64'(v), 1);
    rd(A_TAIL, v); chk("R9 tail held", 64'(v), 3);
    rd(A_STAT, v); chk("R9 halted pending", 64'(v), 5);
    chk("R10 irq masked", 64'(irq), 0);
    chk("R9 status before bad written", 64'(exp_a.size()), 0);
    wr(A_HEAD, 7);
    rd(A_HEAD, v); chk("R10 head write ignored", 64'(v), 4);
    begin
      int reqs = 0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (mem_req) reqs++; end
      chk("R9 no requests when halted", 64'(reqs), 0);
    end

    // R8 repeated head
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(A_BASE, v); chk("R1 base after reset", 64'(v), 0);
    rb = 32'h2000;
    wr(A_BASE, rb);
    put_status(0, 64'h1234, 32'hE000, 0, "R8 status");
    wr(A_HEAD, 1);
    wait_reg(A_TAIL, 1);
    put_raw(1, 64'h9999, {4'd2, 1'b0, 59'(32'hE008)});
    wr(A_HEAD, 1);
    rd(A_ERR, v);  chk("R8 err bit1", 64'(v), 2);
    rd(A_STAT, v); chk("R8 halted", 64'(v), 1);
    wr(A_HEAD, 2);
    repeat (20) @(negedge clk);
    rd(A_TAIL, v); chk("R8 nothing fetched", 64'(v), 1);
    chk("R8 scoreboard empty", 64'(exp_a.size()), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule